// File: doc/BRIEF.md
# Complementary Pair Dead-Time Inserter

This block sits between the compare stage of a PWM channel and the gate drivers of one half bridge. It turns a single raw compare waveform into a high-side drive and a low-side drive that are never on together. Each change of the compare signal turns the conducting side off at once. A down counter is then loaded, and the opposite side turns on only when that counter runs out. While the counter runs, both sides are off.

Two dead-time values, each 6 bits wide, are supplied. In split mode the first value times the gap before the high side turns on, and the second value times the gap before the low side turns on. Each value can then match the switching speed of its own transistor. In per-pair mode one of the two values is picked by a select input, and that value is used for both edges. The same block can then be reused for pairs with different loads.

Top module: `dtu_deadtime_pair`

## Requirements
- R1: `drv_hi` and `drv_lo` are never both 1 in any cycle.
- R2: While `rst_n` is 0, both drives are 0 and the counter is cleared. On the first clock edge after release, with `cmp_in` held low, `drv_lo` becomes 1 and `drv_hi` stays 0.
- R3: When the clock edge samples a change of `cmp_in` and the selected dead time D is not 0, both drives are 0 from that edge onward. The incoming drive (`drv_hi` for a rising change, `drv_lo` for a falling one) becomes 1 exactly D clock edges later, so the gap lasts D cycles.
- R4: With `mode` = 0 (split), a rising change uses `dt_first` and a falling change uses `dt_second`.
- R5: With `mode` = 1 (per pair), both directions use `dt_first` when `pair_sel` = 0 and `dt_second` when `pair_sel` = 1. The value that is not selected has no effect on the gap.
- R6: A selected dead time of 0 swaps the drives on the same clock edge that samples the change, with no cycle in which both are 0.
- R7: If `cmp_in` changes again while the counter is still running, the counter reloads with the value for the new direction. Both drives stay 0 until the new count expires, and the drive of the abandoned direction never turns on.
- R8: Once no count is pending, `drv_hi` equals the registered compare level and `drv_lo` equals its inverse.
- R9: The largest code, 63, gives a gap of 63 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_in | input | 1 | Raw compare output of the PWM channel |
| dt_first | input | 6 | Dead time before high-side turn-on (split), or choice 0 (per pair) |
| dt_second | input | 6 | Dead time before low-side turn-on (split), or choice 1 (per pair) |
| mode | input | 1 | 0 = split per edge direction, 1 = one value for the pair |
| pair_sel | input | 1 | In per-pair mode, picks `dt_second` when 1 and `dt_first` when 0 |
| drv_hi | output | 1 | High-side drive |
| drv_lo | output | 1 | Low-side drive |

## Verification
The counter's countdown and a new compare edge can fall in the same cycle. This happens when `cmp_in` toggles back while a long gap is still being timed. The bench provokes it by reversing the compare level three cycles into a 10-cycle gap. It then judges the result by counting the all-off cycles that follow the second change, which must equal the value for the new direction. It also confirms that the abandoned side never turned on. A second collision, between an edge and a zero dead time, is judged by requiring zero all-off cycles at the swap.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  typedef enum logic {
    DT_SPLIT = 1'b0,
    DT_PAIR  = 1'b1
  } dt_mode_e;

  // Drive levels {hi, lo} for a settled compare level.
  function automatic logic [1:0] settled_drive(input logic level);
    return {level, ~level};
  endfunction

  // Selected dead time for one edge direction.
  function automatic logic [5:0] pick_dead(input dt_mode_e m, input logic sel,
                                           input logic rising,
                                           input logic [5:0] first,
                                           input logic [5:0] second);
    if (m == DT_PAIR) return sel ? second : first;
    return rising ? first : second;
  endfunction
endpackage

// File: rtl/dtu_edge_det.sv
module dtu_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic sig_q,
  output logic rise,
  output logic fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;
  assign fall = ~sig_in & sig_q;
endmodule

// File: rtl/dtu_dt_select.sv
module dtu_dt_select #(
  parameter int DT_W = 6
) (
  input  logic            mode,
  input  logic            pair_sel,
  input  logic            rise,
  input  logic [DT_W-1:0] dt_first,
  input  logic [DT_W-1:0] dt_second,
  output logic [DT_W-1:0] dt_sel
);
  import dtu_pkg::*;

  dt_mode_e mode_e;
  assign mode_e = dt_mode_e'(mode);

  generate
    if (DT_W == 6) begin : g_fn
      assign dt_sel = pick_dead(mode_e, pair_sel, rise, dt_first, dt_second);
    end else begin : g_mux
      always_comb begin
        if (mode_e == DT_PAIR) dt_sel = pair_sel ? dt_second : dt_first;
        else                   dt_sel = rise ? dt_first : dt_second;
      end
    end
  endgenerate
endmodule

// File: rtl/dtu_dt_counter.sv
module dtu_dt_counter #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DT_W-1:0] load_val,
  output logic [DT_W-1:0] cnt,
  output logic            done
);
  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - ONE;
  end

  // Count is on its last step or idle: incoming drive may assert next edge.
  assign done = (cnt <= ONE);
endmodule

// File: rtl/dtu_deadtime_pair.sv
module dtu_deadtime_pair #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_in,
  input  logic [DT_W-1:0] dt_first,
  input  logic [DT_W-1:0] dt_second,
  input  logic            mode,
  input  logic            pair_sel,
  output logic            drv_hi,
  output logic            drv_lo
);
  import dtu_pkg::*;

  logic            cmp_q;
  logic            edge_rise;
  logic            edge_fall;
  logic            edge_any;
  logic [DT_W-1:0] dt_sel;
  logic [DT_W-1:0] cnt_val;
  logic            cnt_done;
  logic            dt_zero;
  logic [1:0]      drv_d;
  logic [1:0]      drv_q;

  dtu_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (cmp_in),
    .sig_q  (cmp_q),
    .rise   (edge_rise),
    .fall   (edge_fall)
  );

  assign edge_any = edge_rise | edge_fall;

  dtu_dt_select #(.DT_W(DT_W)) u_sel (
    .mode      (mode),
    .pair_sel  (pair_sel),
    .rise      (edge_rise),
    .dt_first  (dt_first),
    .dt_second (dt_second),
    .dt_sel    (dt_sel)
  );

  assign dt_zero = (dt_sel == '0);

  dtu_dt_counter #(.DT_W(DT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (edge_any),
    .load_val (dt_sel),
    .cnt      (cnt_val),
    .done     (cnt_done)
  );

  always_comb begin
    if (edge_any)      drv_d = dt_zero ? settled_drive(cmp_in) : 2'b00;
    else if (cnt_done) drv_d = settled_drive(cmp_q);
    else               drv_d = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= 2'b00;
    else        drv_q <= drv_d;
  end

  assign drv_hi = drv_q[1];
  assign drv_lo = drv_q[0];
endmodule

// File: rtl/dtu_deadtime_chk.sv
module dtu_deadtime_chk #(
  parameter int DT_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmp_in,
  input logic [DT_W-1:0] dt_first,
  input logic [DT_W-1:0] dt_second,
  input logic            mode,
  input logic            pair_sel,
  input logic            drv_hi,
  input logic            drv_lo,
  input logic            edge_rise,
  input logic            edge_fall,
  input logic [DT_W-1:0] cnt_val
);
  always_comb begin
    if (rst_n) begin
      AST_NEVER_BOTH_ON: assert (!(drv_hi && drv_lo)); // R1
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!drv_hi && !drv_lo && cnt_val == '0)); // R2

  AST_OFF_WHILE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val != '0) |-> (!drv_hi && !drv_lo)); // R3

  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val > DT_W'(1) && !edge_rise && !edge_fall) |=> (cnt_val == $past(cnt_val) - DT_W'(1))); // R3

  AST_SPLIT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && edge_rise) |=> (cnt_val == $past(dt_first))); // R4

  AST_SPLIT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && edge_fall) |=> (cnt_val == $past(dt_second))); // R4

  AST_PAIR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && (edge_rise || edge_fall)) |=> (cnt_val == (pair_sel ? $past(dt_second) : $past(dt_first)))); // R5

  AST_ZERO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_rise || edge_fall) && cnt_val == '0 && ((!mode && edge_rise && dt_first == '0) || (!mode && edge_fall && dt_second == '0)))
    |=> (drv_hi == $past(cmp_in) && drv_lo == !$past(cmp_in))); // R6

  AST_RETRIGGER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_rise || edge_fall) && cnt_val > DT_W'(1) && !(!mode && edge_rise && dt_first == '0) && !(!mode && edge_fall && dt_second == '0) && !(mode && !pair_sel && dt_first == '0) && !(mode && pair_sel && dt_second == '0))
    |=> (!drv_hi && !drv_lo)); // R7
endmodule

bind dtu_deadtime_pair dtu_deadtime_chk #(.DT_W(DT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_in    (cmp_in),
  .dt_first  (dt_first),
  .dt_second (dt_second),
  .mode      (mode),
  .pair_sel  (pair_sel),
  .drv_hi    (drv_hi),
  .drv_lo    (drv_lo),
  .edge_rise (edge_rise),
  .edge_fall (edge_fall),
  .cnt_val   (cnt_val)
);

// File: tb/sim_dtu_deadtime_pair.sv
`timescale 1ns/1ps
module sim_dtu_deadtime_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_in = 1'b0;
  logic [5:0] dt_first = '0;
  logic [5:0] dt_second = '0;
  logic       mode = 1'b0;
  logic       pair_sel = 1'b0;
  logic       drv_hi;
  logic       drv_lo;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dtu_deadtime_pair u0 (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in),
    .dt_first(dt_first), .dt_second(dt_second),
    .mode(mode), .pair_sel(pair_sel),
    .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  // Vector: {mode, pair_sel, rising, first[6], second[6]}
  localparam int NV = 10;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 6'd4,  6'd9},
    {1'b0, 1'b0, 1'b0, 6'd4,  6'd9},
    {1'b1, 1'b0, 1'b1, 6'd7,  6'd2},
    {1'b1, 1'b0, 1'b0, 6'd7,  6'd2},
    {1'b1, 1'b1, 1'b1, 6'd7,  6'd2},
    {1'b1, 1'b1, 1'b0, 6'd7,  6'd2},
    {1'b0, 1'b0, 1'b1, 6'd0,  6'd3},
    {1'b0, 1'b0, 1'b0, 6'd5,  6'd0},
    {1'b0, 1'b0, 1'b1, 6'd63, 6'd1},
    {1'b0, 1'b1, 1'b0, 6'd1,  6'd1}
  };

  // Expected gap from the requirements (R4, R5).
  function automatic int expect_gap(input bit m, input bit s, input bit r,
                                    input int a, input int b);
    if (m) begin
      if (s) return b;
      return a;
    end
    if (r) return a;
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input bit level);
    @(negedge clk);
    cmp_in = level;
    for (int i = 0; i < 70; i++) @(negedge clk);
  endtask

  // Toggle cmp_in and count the all-off samples until one side turns on.
  task automatic measure(input bit new_level, output int gap, output bit both_seen);
    gap = 0;
    both_seen = 1'b0;
    cmp_in = new_level;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (drv_hi && drv_lo) both_seen = 1'b1;
      if (!drv_hi && !drv_lo) gap++;
      else break;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int  gap;
    bit  both;
    int  exp;

    // R2: reset state
    repeat (3) @(negedge clk);
    check(!drv_hi && !drv_lo, "R2 reset drives", {drv_hi, drv_lo}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(drv_lo && !drv_hi, "R2 first edge after release", {drv_hi, drv_lo}, 1);

    // Table walk: R3, R4, R5, R6, R9
    for (int v = 0; v < NV; v++) begin
      mode      = VEC[v][14];
      pair_sel  = VEC[v][13];
      dt_first  = VEC[v][11:6];
      dt_second = VEC[v][5:0];
      settle(!VEC[v][12]);
      // R8: settled outputs follow compare level
      check(drv_hi == !VEC[v][12] && drv_lo == VEC[v][12], "R8 settled follow",
            {drv_hi, drv_lo}, {!VEC[v][12], VEC[v][12]});
      exp = expect_gap(VEC[v][14], VEC[v][13], VEC[v][12], VEC[v][11:6], VEC[v][5:0]);
      measure(VEC[v][12], gap, both);
      check(gap == exp, (exp == 0) ? "R6 zero gap" : ((exp == 63) ? "R9 max gap" :
            (VEC[v][14] ? "R5 pair gap" : "R4 split gap")), gap, exp);
      check(drv_hi == VEC[v][12] && drv_lo == !VEC[v][12], "R3 incoming side",
            {drv_hi, drv_lo}, {VEC[v][12], !VEC[v][12]});
      check(!both, "R1 overlap", both, 0);
    end

    // R5: unselected value changed mid-pattern has no effect
    mode = 1'b1; pair_sel = 1'b1; dt_first = 6'd20; dt_second = 6'd3;
    settle(1'b0);
    dt_first = 6'd40;
    measure(1'b1, gap, both);
    check(gap == 3, "R5 unselected ignored", gap, 3);

    // R7: retrigger during a count
    mode = 1'b0; pair_sel = 1'b0; dt_first = 6'd10; dt_second = 6'd5;
    settle(1'b0);
    cmp_in = 1'b1;
    both = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (drv_hi || drv_lo) both = 1'b1;
    end
    check(!both, "R7 off before retrigger", both, 0);
    measure(1'b0, gap, both);
    check(gap == 5, "R7 reload gap", gap, 5);
    check(drv_lo && !drv_hi, "R7 abandoned side stays off", {drv_hi, drv_lo}, 1);

    // R1/R6: zero dead time rapid toggles
    dt_first = 6'd0; dt_second = 6'd0;
    settle(1'b0);
    both = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cmp_in = ~cmp_in;
      @(negedge clk);
      if (drv_hi == drv_lo) both = 1'b1;
    end
    check(!both, "R6 zero toggles never gap", both, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule